// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Decoder

This block takes a stream of 16-bit instruction parcels over a valid/ready handshake and turns it into a stream of decoded operations, at most one per clock. Every parcel is read through nested format bits. The most significant bit picks the ordinary three-operand 16-bit form. If that bit does not pick it, the next bit separates the head of a 32-bit instruction from an alternate 16-bit form. Inside the alternate form, a two-bit selector picks one of three instructions that carry a 12-bit payload, or a pair of 6-bit shortcut operations.

Each operation leaves the block as a registered pulse with a 3-bit kind tag and a 32-bit payload. A 32-bit instruction leaves the block only after its second parcel has been taken in. A shortcut pair is issued over two consecutive cycles, and the input is held off while the second operation waits. A flush input drops any half-built 32-bit instruction and any waiting shortcut.

Top module: `parcel_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A parcel accepted with bit 15 = 0 produces, on the next cycle, out_valid = 1 with kind 0 (ordinary 16-bit) and the parcel zero-extended as payload.
- R3: An accepted parcel with bits 15:12 = 4'b1000, 4'b1001 or 4'b1010 produces, on the next cycle, kind 2 (relative jump), 3 (load-immediate) or 4 (annotate) respectively, with payload equal to bits 11:0 zero-extended.
- R4: An accepted parcel with bits 15:12 = 4'b1011 produces two kind-5 (shortcut) operations on consecutive cycles: first bits 11:6, then bits 5:0, each zero-extended. Slot code 6'b000000 (shortcut NOP) is emitted like any other code.
- R5: While the second shortcut slot is waiting, in_ready is 0 and no parcel is taken. A parcel held on the input is accepted on the following cycle.
- R6: An accepted parcel with bits 15:14 = 2'b11 produces no output. The next accepted parcel, whatever its bits, completes the instruction: one cycle later the block emits kind 1 with payload {first parcel, second parcel}.
- R7: Asserting flush after the head of a 32-bit instruction discards it, so the next parcel is decoded on its own format bits.
- R8: Asserting flush discards a waiting second shortcut slot and any parcel offered in the same cycle. No output follows a flush cycle, and in_ready is 1 afterwards.
- R9: out_kind never holds a code above 5, and the payloads of kinds 2 to 5 have bits 31:12 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops partial and pending state, and any parcel offered this cycle |
| in_valid | input | 1 | Parcel on in_data is offered |
| in_ready | output | 1 | Decoder can take a parcel this cycle |
| in_data | input | 16 | Instruction parcel |
| out_valid | output | 1 | A decoded operation is present this cycle |
| out_kind | output | 3 | Kind tag: 0 ord16, 1 long32, 2 jrel, 3 ldi, 4 annotate, 5 shortcut |
| out_payload | output | 32 | Zero-extended operand field of the operation |

## Verification
The bench builds the decoder with its default 16-bit parcel and 32-bit payload. With these values every format code, both shortcut slots and a complete two-parcel instruction fit in the output word, so each branch of the format tree can be reached from the ports. The parcels are chosen to push the corners: all-ones and all-zero fields, shortcut NOP pairs, a second parcel whose bits would look like a shortcut or a 32-bit head, and back-to-back parcels that must stall behind a shortcut pair. Flush is placed right after a 32-bit head and right after a shortcut pair, and also while a parcel is being offered.

// File: rtl/parcel_pkg.sv
package parcel_pkg;

    // Output kind tags (values are part of the external contract)
    typedef enum logic [2:0] {
        K_ORD16  = 3'd0,
        K_LONG32 = 3'd1,
        K_JREL   = 3'd2,
        K_LDI    = 3'd3,
        K_ANNOT  = 3'd4,
        K_SHORT  = 3'd5
    } op_kind_e;

    // Classification of one parcel seen on its own
    typedef enum logic [1:0] {
        PC_ORD,
        PC_LONG_HEAD,
        PC_ALT_FIELD,
        PC_ALT_PAIR
    } parcel_class_e;

endpackage

// File: rtl/parcel_classify.sv
module parcel_classify
    import parcel_pkg::*;
#(
    parameter int PARCEL_W = 16
) (
    input  logic [PARCEL_W-1:0]       parcel,
    output parcel_class_e             pclass,
    output op_kind_e                  field_kind,
    output logic [PARCEL_W-5:0]       field,
    output logic [(PARCEL_W-4)/2-1:0] slot_first,
    output logic [(PARCEL_W-4)/2-1:0] slot_second
);
    localparam int FIELD_W = PARCEL_W - 4;
    localparam int SLOT_W  = FIELD_W / 2;
    localparam int TOP     = PARCEL_W - 1;

    logic [1:0]        sub_sel;
    logic [SLOT_W-1:0] slots [2];

    assign sub_sel = parcel[TOP-2 -: 2];
    assign field   = parcel[FIELD_W-1:0];

    // Slot 0 is the upper half of the field and is issued first
    for (genvar g = 0; g < 2; g++) begin : g_slot
        assign slots[g] = field[FIELD_W-1-g*SLOT_W -: SLOT_W];
    end
    assign slot_first  = slots[0];
    assign slot_second = slots[1];

    always_comb begin
        field_kind = K_JREL;
        if (!parcel[TOP]) begin
            pclass = PC_ORD;
        end else if (parcel[TOP-1]) begin
            pclass = PC_LONG_HEAD;
        end else if (sub_sel == 2'b11) begin
            pclass = PC_ALT_PAIR;
        end else begin
            pclass = PC_ALT_FIELD;
            case (sub_sel)
                2'b00:   field_kind = K_JREL;
                2'b01:   field_kind = K_LDI;
                default: field_kind = K_ANNOT;
            endcase
        end
    end

endmodule

// File: rtl/parcel_zext.sv
module parcel_zext #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    if (OUT_W > IN_W) begin : g_pad
        assign dout = {{(OUT_W-IN_W){1'b0}}, din};
    end else begin : g_cut
        assign dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/parcel_decoder.sv
module parcel_decoder
    import parcel_pkg::*;
#(
    parameter int PARCEL_W = 16,
    parameter int OUT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PARCEL_W-1:0] in_data,
    output logic                out_valid,
    output logic [2:0]          out_kind,
    output logic [OUT_W-1:0]    out_payload
);
    localparam int FIELD_W = PARCEL_W - 4;
    localparam int SLOT_W  = FIELD_W / 2;
    localparam int LONG_W  = 2 * PARCEL_W;

    typedef struct packed {
        logic                have_hi;
        logic [PARCEL_W-1:0] hi;
        logic                pend;
        logic [SLOT_W-1:0]   pend_slot;
        logic                ovalid;
        op_kind_e            okind;
        logic [OUT_W-1:0]    opay;
    } state_t;

    state_t st_d, st_q;

    parcel_class_e     pclass;
    op_kind_e          field_kind;
    logic [FIELD_W-1:0] field;
    logic [SLOT_W-1:0] slot_a, slot_b;
    logic [OUT_W-1:0]  pay_ord, pay_field, pay_slot_a, pay_slot_b, pay_long;
    logic              take;

    parcel_classify #(.PARCEL_W(PARCEL_W)) u_classify (
        .parcel      (in_data),
        .pclass      (pclass),
        .field_kind  (field_kind),
        .field       (field),
        .slot_first  (slot_a),
        .slot_second (slot_b)
    );

    parcel_zext #(.IN_W(PARCEL_W), .OUT_W(OUT_W)) u_zx_ord  (.din(in_data),          .dout(pay_ord));
    parcel_zext #(.IN_W(FIELD_W),  .OUT_W(OUT_W)) u_zx_fld  (.din(field),            .dout(pay_field));
    parcel_zext #(.IN_W(SLOT_W),   .OUT_W(OUT_W)) u_zx_sa   (.din(slot_a),           .dout(pay_slot_a));
    parcel_zext #(.IN_W(SLOT_W),   .OUT_W(OUT_W)) u_zx_sb   (.din(st_q.pend_slot),   .dout(pay_slot_b));
    parcel_zext #(.IN_W(LONG_W),   .OUT_W(OUT_W)) u_zx_long (.din({st_q.hi, in_data}), .dout(pay_long));

    assign in_ready = !st_q.pend;
    assign take     = in_valid && in_ready && !flush;

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        if (flush) begin
            st_d.have_hi = 1'b0;
            st_d.pend    = 1'b0;
        end else if (st_q.pend) begin
            st_d.pend   = 1'b0;
            st_d.ovalid = 1'b1;
            st_d.okind  = K_SHORT;
            st_d.opay   = pay_slot_b;
        end else if (take) begin
            if (st_q.have_hi) begin
                st_d.have_hi = 1'b0;
                st_d.ovalid  = 1'b1;
                st_d.okind   = K_LONG32;
                st_d.opay    = pay_long;
            end else begin
                case (pclass)
                    PC_ORD: begin
                        st_d.ovalid = 1'b1;
                        st_d.okind  = K_ORD16;
                        st_d.opay   = pay_ord;
                    end
                    PC_LONG_HEAD: begin
                        st_d.have_hi = 1'b1;
                        st_d.hi      = in_data;
                    end
                    PC_ALT_PAIR: begin
                        st_d.ovalid    = 1'b1;
                        st_d.okind     = K_SHORT;
                        st_d.opay      = pay_slot_a;
                        st_d.pend      = 1'b1;
                        st_d.pend_slot = slot_b;
                    end
                    default: begin
                        st_d.ovalid = 1'b1;
                        st_d.okind  = field_kind;
                        st_d.opay   = pay_field;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.ovalid;
    assign out_kind    = st_q.okind;
    assign out_payload = st_q.opay;

    // R4 / R5: a shortcut pair blocks the input for the following cycle
    p_pair_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !st_q.have_hi && in_data[PARCEL_W-1 -: 4] == 4'b1011) |=> !in_ready)
        else $error("input not stalled behind shortcut pair");

    // R4: the waiting slot is issued the next cycle unless flushed
    p_second_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !flush) |=> (out_valid && out_kind == 3'd5))
        else $error("second shortcut slot not issued");

    // R6: a 32-bit head alone emits nothing
    p_head_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !st_q.have_hi && in_data[PARCEL_W-1 -: 2] == 2'b11) |=> !out_valid)
        else $error("output after 32-bit head");

    // R8: flush leaves no output and an open input
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && in_ready))
        else $error("activity after flush");

    // R9: only defined kinds are produced
    p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind <= 3'd5)
        else $error("undefined kind");

    // R9: short-field kinds keep the upper payload clear
    p_field_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind >= 3'd2) |-> out_payload[OUT_W-1:FIELD_W] == '0)
        else $error("payload not zero-extended");

endmodule

// File: tb/parcel_decoder_bench.sv
module parcel_decoder_bench;

    localparam logic [2:0] KO = 3'd0, KL = 3'd1, KJ = 3'd2, KI = 3'd3, KA = 3'd4, KS = 3'd5;

    typedef struct {
        logic [2:0]  kind;
        logic [31:0] pay;
        int          req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [2:0]  out_kind;
    logic [31:0] out_payload;

    int   checks = 0;
    int   errors = 0;
    exp_t expq[$];
    logic        m_have_hi = 1'b0;
    logic [15:0] m_hi = '0;

    always #5 clk = ~clk;

    parcel_decoder u_parcel_decoder (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_payload(out_payload)
    );

    function automatic void push(input logic [2:0] k, input logic [31:0] p, input int r);
        exp_t e;
        e.kind = k; e.pay = p; e.req = r;
        expq.push_back(e);
    endfunction

    // Reference model from the requirements
    function automatic void model(input logic [15:0] p, input bit drop_second);
        if (m_have_hi) begin
            push(KL, {m_hi, p}, 6);
            m_have_hi = 1'b0;
        end else if (!p[15]) begin
            push(KO, {16'h0, p}, 2);
        end else if (p[14]) begin
            m_have_hi = 1'b1;
            m_hi = p;
        end else if (p[13:12] == 2'b11) begin
            push(KS, {26'h0, p[11:6]}, 4);
            if (!drop_second) push(KS, {26'h0, p[5:0]}, 4);
        end else begin
            push(p[13:12] == 2'b00 ? KJ : (p[13:12] == 2'b01 ? KI : KA), {20'h0, p[11:0]}, 3);
        end
    endfunction

    task automatic send(input logic [15:0] p, input bit drop_second = 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = p;
        while (!in_ready) @(negedge clk);
        model(p, drop_second);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_flush(input bit with_parcel);
        @(negedge clk);
        flush    = 1'b1;
        in_valid = with_parcel;
        in_data  = 16'h1234;
        @(negedge clk);
        flush    = 1'b0;
        in_valid = 1'b0;
        m_have_hi = 1'b0;
    endtask

    task automatic check_bit(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected output: actual kind %0d payload %h expected none",
                         out_kind, out_payload);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (out_kind !== e.kind || out_payload !== e.pay) begin
                    errors++;
                    $display("FAIL R%0d: actual kind %0d payload %h expected kind %0d payload %h",
                             e.req, out_kind, out_payload, e.kind, e.pay);
                end
                if (e.kind >= KJ) begin
                    checks++;
                    if (out_payload[31:12] !== 20'h0) begin // R9
                        errors++;
                        $display("FAIL R9 upper payload: actual %h expected 0", out_payload[31:12]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit(out_valid, 1'b0, "R1", "out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R1", "out_valid after reset");
        check_bit(in_ready, 1'b1, "R1", "in_ready after reset");

        // R2 ordinary parcels
        send(16'h1234);
        send(16'h7FFF);
        send(16'h0000);
        // R3 alternate payload forms, back to back
        send(16'h8ABC);
        send(16'h9FFF);
        send(16'hA001);
        send(16'h8000);
        idle(2);

        // R4 shortcut pair, then R5 stall check with input released
        send(16'hBFC1);
        @(negedge clk);
        in_valid = 1'b0;
        check_bit(in_ready, 1'b0, "R5", "in_ready while slot pending");
        @(negedge clk);
        check_bit(in_ready, 1'b1, "R5", "in_ready after second slot");

        // R4 NOP pair; R5 held parcels behind pairs
        send(16'hB000);
        send(16'h4321);
        send(16'hB03F);
        send(16'hBFFF);
        send(16'h8123);
        idle(2);

        // R6 32-bit joins; second parcel bits not interpreted
        send(16'hC123);
        idle(3);
        send(16'h3FFF);
        send(16'hFFFF);
        send(16'hB000);
        send(16'hC000);
        send(16'hC5A5);
        idle(2);

        // R7 flush after a 32-bit head
        send(16'hD00D);
        do_flush(1'b0);
        send(16'hB001);
        idle(3);

        // R8 flush drops the waiting slot and an offered parcel
        send(16'hBFC1, 1'b1);
        do_flush(1'b1);
        check_bit(in_ready, 1'b1, "R8", "in_ready after flush");
        check_bit(out_valid, 1'b0, "R8", "out_valid after flush");
        send(16'h0055);
        idle(4);

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R6 missing outputs: actual %0d left expected 0", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule